// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

The block is a free-running periodic timer on a single-cycle register port. An input clock is divided by a programmable prescaler into count ticks. A down-counter steps once per tick. When a step lands the counter on the value held in a compare register, a sticky event flag sets. If interrupts are enabled, a level interrupt follows that flag. In reload mode the counter restarts from a load register after reaching zero. In free mode it wraps to all-ones. Either way the period repeats without software help.

Software programs the divide ratio, load value and compare value, then sets the enable bit. Two optional controls affect that moment. One restarts the count from the load value at enable. The other copies every load-register write straight into the counter. A wait input from the power controller freezes the timer unless the run-in-wait bit is set.

Top module: `ptimer`

## Requirements
- R1: After reset, CONTROL (word 0) reads 0, STATUS (word 1) reads 0, LOAD (word 2) reads all-ones, COMPARE (word 3) reads 0, COUNT (word 4) reads all-ones, and irq_o is low. Unmapped words read 0. Writes to COUNT are ignored. CONTROL bits are: 0 enable, 1 start-from-load, 2 interrupt enable, 3 reload, 4 run-in-wait, 5 load-overwrite, and [27:16] prescale (divide ratio minus one).
- R2: While running, the timer produces one count tick every prescale+1 clock cycles. The prescaler is cleared while the timer is disabled, so the first tick comes prescale+1 cycles after the enabling write.
- R3: On each tick a nonzero count decrements by one. In reload mode, a count of zero is replaced by the LOAD value.
- R4: With reload off, a count of zero steps to all-ones on the next tick. Compare events still occur.
- R5: The STATUS flag (bit 0) sets on the edge where a tick steps the counter to the COMPARE value. A counter change caused by a register write raises no event.
- R6: Writing 1 to STATUS bit 0 clears the flag. Writing 0 leaves it unchanged.
- R7: irq_o is high exactly while the flag is set and the interrupt enable bit is set.
- R8: When the enable bit goes from 0 to 1 with start-from-load set in the same write, the counter takes the LOAD value. Without start-from-load it resumes from its held count.
- R9: With load-overwrite set, a LOAD write also sets the counter to the written value in the same cycle. With it clear, the counter is untouched.
- R10: While wait_i is high and run-in-wait is clear, the counter and prescaler hold. With run-in-wait set, counting continues.
- R11: Clearing the enable bit stops counting, and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| wait_i | input | 1 | Wait-mode indication |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:
- the count holds while the timer is disabled or frozen by wait;
- each tick decrements a nonzero count or reloads a zero one;
- the flag, once set, stays set until a write-one clear;
- a rising flag coincides with the count sitting at the compare value;
- the interrupt stays low whenever it is disabled.

Only the bench scenarios can show the exact tick spacing for each prescale value, or the period and the first event time for a given load and compare value. The same holds for the prescaler restart after a disable, the behaviour on enable with and without start-from-load, and the free-mode wrap to all-ones.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int unsigned AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_LOAD = 3'd2,
    A_CMP  = 3'd3,
    A_CNT  = 3'd4
  } reg_addr_e;

  localparam int unsigned B_EN        = 0;
  localparam int unsigned B_FROM_LOAD = 1;
  localparam int unsigned B_IRQ_EN    = 2;
  localparam int unsigned B_RELOAD    = 3;
  localparam int unsigned B_WAIT_RUN  = 4;
  localparam int unsigned B_LOAD_OW   = 5;
  localparam int unsigned B_PS_LSB    = 16;
  localparam int unsigned B_FLAG      = 0;

  typedef struct packed {
    logic en;
    logic from_load;
    logic irq_en;
    logic reload;
    logic wait_run;
    logic load_ow;
  } ctrl_t;
endpackage

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned PS_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            ev_i,
  input  logic [DW-1:0]   cnt_i,
  output ctrl_t           ctrl_o,
  output logic [PS_W-1:0] ps_o,
  output logic [DW-1:0]   load_o,
  output logic [DW-1:0]   cmp_o,
  output logic            flag_o,
  output logic            load_start_o,
  output logic            ow_wr_o,
  output logic [DW-1:0]   rdata_o
);
  ctrl_t           ctrl_q;
  logic [PS_W-1:0] ps_q;
  logic [DW-1:0]   load_q, cmp_q;
  logic            flag_q;
  logic            wr_ctrl, wr_stat, wr_load, wr_cmp;

  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_load = wr_i && (addr_i == A_LOAD);
  assign wr_cmp  = wr_i && (addr_i == A_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ps_q   <= '0;
      load_q <= '1;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en        <= wdata_i[B_EN];
        ctrl_q.from_load <= wdata_i[B_FROM_LOAD];
        ctrl_q.irq_en    <= wdata_i[B_IRQ_EN];
        ctrl_q.reload    <= wdata_i[B_RELOAD];
        ctrl_q.wait_run  <= wdata_i[B_WAIT_RUN];
        ctrl_q.load_ow   <= wdata_i[B_LOAD_OW];
        ps_q             <= wdata_i[B_PS_LSB +: PS_W];
      end
      if (wr_load) load_q <= wdata_i;
      if (wr_cmp)  cmp_q  <= wdata_i;
      // a new event wins over a same-cycle clear
      if (ev_i) flag_q <= 1'b1;
      else if (wr_stat && wdata_i[B_FLAG]) flag_q <= 1'b0;
    end
  end

  // rising enable with start-from-load in the same write
  assign load_start_o = wr_ctrl && wdata_i[B_EN] && wdata_i[B_FROM_LOAD] && !ctrl_q.en;
  assign ow_wr_o      = wr_load && ctrl_q.load_ow;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_EN]              = ctrl_q.en;
        rdata_o[B_FROM_LOAD]       = ctrl_q.from_load;
        rdata_o[B_IRQ_EN]          = ctrl_q.irq_en;
        rdata_o[B_RELOAD]          = ctrl_q.reload;
        rdata_o[B_WAIT_RUN]        = ctrl_q.wait_run;
        rdata_o[B_LOAD_OW]         = ctrl_q.load_ow;
        rdata_o[B_PS_LSB +: PS_W]  = ps_q;
      end
      A_STAT:  rdata_o[B_FLAG] = flag_q;
      A_LOAD:  rdata_o = load_q;
      A_CMP:   rdata_o = cmp_q;
      A_CNT:   rdata_o = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign ps_o   = ps_q;
  assign load_o = load_q;
  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
  parameter int unsigned PS_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            run_i,
  input  logic [PS_W-1:0] div_i,
  output logic            tick_o
);
  logic [PS_W-1:0] pc_q;

  // >= keeps a shrunk divide ratio from stranding the counter above it
  assign tick_o = run_i && (pc_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (!en_i)  pc_q <= '0;
    else if (run_i)  pc_q <= tick_o ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/ptimer_down_cnt.sv
module ptimer_down_cnt #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reload_i,
  input  logic          load_start_i,
  input  logic          ow_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] load_i,
  input  logic [DW-1:0] cmp_i,
  output logic [DW-1:0] cnt_o,
  output logic          ev_o
);
  logic [DW-1:0] cnt_q, step_d;

  always_comb begin
    if (cnt_q == '0) step_d = reload_i ? load_i : '1;
    else             step_d = cnt_q - 1'b1;
  end

  // only a counting step can raise an event
  assign ev_o = tick_i && !ow_wr_i && (step_d == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '1;
    else if (load_start_i) cnt_q <= load_i;
    else if (ow_wr_i)      cnt_q <= wdata_i;
    else if (tick_i)       cnt_q <= step_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ptimer.sv
module ptimer
  import ptimer_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned PS_W = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          wait_i,
  output logic          irq_o
);
  ctrl_t           ctrl;
  logic [PS_W-1:0] ps;
  logic [DW-1:0]   load_val, cmp_val, cnt_val;
  logic            flag, ev, tick, run, load_start, ow_wr;

  assign run   = ctrl.en && (!wait_i || ctrl.wait_run);
  assign irq_o = flag && ctrl.irq_en;

  ptimer_regs #(.DW(DW), .PS_W(PS_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .ev_i         (ev),
    .cnt_i        (cnt_val),
    .ctrl_o       (ctrl),
    .ps_o         (ps),
    .load_o       (load_val),
    .cmp_o        (cmp_val),
    .flag_o       (flag),
    .load_start_o (load_start),
    .ow_wr_o      (ow_wr),
    .rdata_o      (rdata_o)
  );

  ptimer_prescale #(.PS_W(PS_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.en),
    .run_i  (run),
    .div_i  (ps),
    .tick_o (tick)
  );

  ptimer_down_cnt #(.DW(DW)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .reload_i     (ctrl.reload),
    .load_start_i (load_start),
    .ow_wr_i      (ow_wr),
    .wdata_i      (wdata_i),
    .load_i       (load_val),
    .cmp_i        (cmp_val),
    .cnt_o        (cnt_val),
    .ev_o         (ev)
  );
endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk
  import ptimer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [2:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          wait_i,
  input logic          irq_o,
  input logic          en,
  input logic          irq_en,
  input logic          reload,
  input logic          wait_run,
  input logic          flag,
  input logic          tick,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] load_val,
  input logic [DW-1:0] cmp_val
);
  p_hold_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_i) |=> $stable(cnt));

  p_wait_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && wait_i && !wait_run && !wr_i) |=> $stable(cnt));

  p_step_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt != '0 && !wr_i) |=> (cnt == $past(cnt) - 1'b1));

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == '0 && reload && !wr_i) |=> (cnt == $past(load_val)));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == '0 && !reload && !wr_i) |=> (cnt == '1));

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !(wr_i && addr_i == A_STAT && wdata_i[B_FLAG])) |=> flag);

  p_event_at_cmp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag) && !$past(wr_i)) |-> (cnt == cmp_val));

  p_irq_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |-> !irq_o);
endmodule

bind ptimer ptimer_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wait_i   (wait_i),
  .irq_o    (irq_o),
  .en       (ctrl.en),
  .irq_en   (ctrl.irq_en),
  .reload   (ctrl.reload),
  .wait_run (ctrl.wait_run),
  .flag     (flag),
  .tick     (tick),
  .cnt      (cnt_val),
  .load_val (load_val),
  .cmp_val  (cmp_val)
);

// File: tb/sim_ptimer.sv
module sim_ptimer;
  localparam int unsigned DW = 32;
  localparam logic [2:0] W_CTRL = 3'd0, W_STAT = 3'd1, W_LOAD = 3'd2, W_CMP = 3'd3, W_CNT = 3'd4;
  localparam logic [31:0] C_EN = 32'd1, C_FL = 32'd2, C_IRQ = 32'd4, C_RL = 32'd8,
                          C_WR = 32'd16, C_OW = 32'd32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          wait_in = 1'b0;
  logic          irq;
  int            total = 0;
  int            bad = 0;
  logic          done = 1'b0;

  always #4 clk = ~clk;

  ptimer u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .wait_i  (wait_in),
    .irq_o   (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_tests;
    logic [31:0] v;
    // reset state, R1
    rd_reg(W_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd_reg(W_STAT, v); chk("R1 stat", v, 32'h0);
    rd_reg(W_LOAD, v); chk("R1 load", v, 32'hFFFF_FFFF);
    rd_reg(W_CMP, v);  chk("R1 cmp", v, 32'h0);
    rd_reg(W_CNT, v);  chk("R1 count", v, 32'hFFFF_FFFF);
    rd_reg(3'd6, v);   chk("R1 unmapped", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // overwrite, R9 and R5 (write-caused match raises no event)
    wr_reg(W_CMP, 32'd7);
    wr_reg(W_CTRL, C_OW);
    wr_reg(W_LOAD, 32'd7);
    rd_reg(W_CNT, v);  chk("R9 overwrite on", v, 32'd7);
    rd_reg(W_STAT, v); chk("R5 no event on write", v, 32'd0);
    wr_reg(W_CTRL, 32'd0);
    wr_reg(W_LOAD, 32'd9);
    rd_reg(W_CNT, v);  chk("R9 overwrite off", v, 32'd7);
    wr_reg(W_CNT, 32'd5);
    rd_reg(W_CNT, v);  chk("R1 count read-only", v, 32'd7);

    // sweep prescale, load and compare in reload mode, R2 R3 R5 R7 R8
    for (int d = 0; d < 4; d++) begin
      for (int l = 0; l < 6; l++) begin
        for (int cs = 0; cs < 2; cs++) begin
          int c, mc, ph;
          logic mf;
          c = (cs == 0) ? 0 : l;
          wr_reg(W_CTRL, 32'd0);
          wr_reg(W_STAT, 32'd1);
          wr_reg(W_LOAD, l);
          wr_reg(W_CMP, c);
          wr_reg(W_CTRL, C_EN | C_FL | C_IRQ | C_RL | (d << 16));
          mc = l; mf = 1'b0; ph = 0;
          rd_reg(W_CNT, v); chk("R8 start from load", v, l);
          for (int n = 1; n <= 2 * (l + 1) * (d + 1) + 1; n++) begin
            @(negedge clk);
            ph++;
            if (ph == d + 1) begin
              ph = 0;
              mc = (mc == 0) ? l : mc - 1;
              if (mc == c) mf = 1'b1;
            end
            rd_reg(W_CNT, v);  chk("R3 count", v, mc);
            rd_reg(W_STAT, v); chk("R5 flag", v, {31'd0, mf});
            chk("R7 irq", {31'd0, irq}, {31'd0, mf});
          end
        end
      end
    end

    // disable hold R11, resume R8, wait R10
    wr_reg(W_CTRL, 32'd0);
    wr_reg(W_STAT, 32'd1);
    wr_reg(W_CMP, 32'd1000);
    wr_reg(W_CTRL, C_OW);
    wr_reg(W_LOAD, 32'd7);
    wr_reg(W_CTRL, 32'd0);
    wr_reg(W_LOAD, 32'd9);
    wr_reg(W_CTRL, C_EN | C_RL);
    rd_reg(W_CNT, v); chk("R8 resume at enable", v, 32'd7);
    step(2);
    rd_reg(W_CNT, v); chk("R3 running", v, 32'd5);
    wr_reg(W_CTRL, C_RL);
    rd_reg(W_CNT, v); chk("R11 stop value", v, 32'd3);
    step(5);
    rd_reg(W_CNT, v); chk("R11 held", v, 32'd3);
    wr_reg(W_CTRL, C_EN | C_RL);
    rd_reg(W_CNT, v); chk("R8 resume held", v, 32'd3);
    wait_in = 1'b1;
    step(3);
    rd_reg(W_CNT, v); chk("R10 frozen", v, 32'd3);
    wr_reg(W_CTRL, C_EN | C_RL | C_WR);
    rd_reg(W_CNT, v); chk("R10 frozen at write", v, 32'd3);
    step(1);
    rd_reg(W_CNT, v); chk("R10 run in wait", v, 32'd2);
    wait_in = 1'b0;

    // prescaler restart after disable, R2
    wr_reg(W_CTRL, 32'd0);
    wr_reg(W_LOAD, 32'd20);
    wr_reg(W_CTRL, C_EN | C_FL | C_RL | (32'd3 << 16));
    step(1);
    wr_reg(W_CTRL, C_RL | (32'd3 << 16));
    rd_reg(W_CNT, v); chk("R2 before restart", v, 32'd20);
    wr_reg(W_CTRL, C_EN | C_RL | (32'd3 << 16));
    step(3);
    rd_reg(W_CNT, v); chk("R2 no early tick", v, 32'd20);
    step(1);
    rd_reg(W_CNT, v); chk("R2 first tick", v, 32'd19);

    // free mode wrap R4, masked irq R7, clear R6
    wr_reg(W_CTRL, 32'd0);
    wr_reg(W_STAT, 32'd1);
    wr_reg(W_LOAD, 32'd2);
    wr_reg(W_CMP, 32'hFFFF_FFFF);
    wr_reg(W_CTRL, C_EN | C_FL);
    step(2);
    rd_reg(W_CNT, v); chk("R4 at zero", v, 32'd0);
    step(1);
    rd_reg(W_CNT, v);  chk("R4 wrap", v, 32'hFFFF_FFFF);
    rd_reg(W_STAT, v); chk("R4 event on wrap", v, 32'd1);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    step(1);
    rd_reg(W_CNT, v); chk("R4 after wrap", v, 32'hFFFF_FFFE);
    wr_reg(W_STAT, 32'd0);
    rd_reg(W_STAT, v); chk("R6 write zero", v, 32'd1);
    wr_reg(W_STAT, 32'd1);
    rd_reg(W_STAT, v); chk("R6 write one", v, 32'd0);
    wr_reg(W_CTRL, 32'd0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    fork
      begin run_tests(); done = 1'b1; end
      begin repeat (150000) @(posedge clk); end
    join_any
    disable fork;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule